// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block is a single-channel DMA engine that runs a transfer as a chain of transfer descriptors. Each descriptor names one contiguous segment: where it is read from, where it is written to, how many words it holds, and which descriptor runs next. When a descriptor finishes, the engine follows its link. This lets one transfer gather scattered pieces (for example a header, a payload and a trailer) into one destination run. It also lets one contiguous source be split across several separate regions.

The descriptors sit in a small on-chip table. The table is also decoded inside the engine's own write address space, at the window starting at `DESC_BASE`. A descriptor whose destination falls in that window therefore rewrites other descriptors. With this, a chain can load a new configuration into a second descriptor, branch to it, and be branched back to, repeating as often as the loaded data asks.

Software fills the table through a simple write port while the engine is idle. It then pulses `start` with the index of the first descriptor. Data moves through separate read and write ports to a synchronous memory with one cycle of read latency. At the end of the chain the engine raises a completion pulse.

Top module: `cdma_chain_engine`

## Requirements
- R1: Out of reset the engine is idle: `busy` and `done` are low, and neither `mem_rd_en` nor `mem_wr_en` is asserted while `busy` is low.
- R2: Descriptor n occupies table words 4n+0 (source address), 4n+1 (destination address), 4n+2 (word count) and 4n+3 (control). A `cfg_we` write to `cfg_addr` updates that table word when the engine is idle.
- R3: The control word holds bit 0 = end of chain, bit 1 = source increment, bit 2 = destination increment, and bits 3 and up = next descriptor index. A descriptor with count N copies N words from source to destination, with each address advancing by one per word when its increment bit is set.
- R4: A descriptor without the end-of-chain bit hands over to the descriptor named in its next field, so segments from separate source regions land back to back in one destination run.
- R5: A chain can split one contiguous source across several separate destination regions, one descriptor per region, in chain order.
- R6: With the source increment bit clear, every word is read from the same address. With the destination increment bit clear, every word is written to the same address, and the last word read is the one that remains.
- R7: A write whose destination lies in the window of 4·NUM_TD words starting at `DESC_BASE` updates the descriptor table at the offset within the window. It never appears on `mem_wr_en`.
- R8: Descriptor fields are sampled when the descriptor is loaded. A rewrite of a descriptor takes effect the next time that descriptor is loaded, including a descriptor that rewrites its own source field while it runs. A descriptor can reconfigure another descriptor, branch to it, and be branched back to.
- R9: When a descriptor with the end-of-chain bit completes, `done` is high for exactly one cycle, `busy` is low in that cycle, and every write of the chain has already landed.
- R10: A descriptor with count 0 makes no memory access and follows its link, or ends the chain if its end-of-chain bit is set.
- R11: While `busy` is high, `start` and `cfg_we` are ignored.
- R12: Within one descriptor of count N, reads are issued on N consecutive cycles, and every write follows its read by two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor table write strobe (idle only) |
| cfg_addr | input | DT_AW | Table word address, 4·index + word |
| cfg_wdata | input | DATA_W | Table write data |
| start | input | 1 | Start pulse (idle only) |
| start_idx | input | IDX_W | Index of the first descriptor |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | DATA_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | DATA_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| busy | output | 1 | High from start until chain completion |
| done | output | 1 | One-cycle chain completion pulse |

## Verification
A wrong internal state shows up as data at the wrong place in memory. A miscounted segment leaves a word missing or duplicated in the destination run, and this is visible as soon as `done` arrives. A bad link or a wrongly decoded control bit sends the chain to another descriptor. That shows as missing segments, as extra reads in the read count, or as a chain that never ends and is caught by a timeout. A broken descriptor-window decode either leaks a write onto `mem_wr_en`, which the assertion catches at that cycle, or leaves the reloaded descriptor stale. The stale case surfaces in the reconfiguration loops as wrong destinations at the end of the chain.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int WORDS_PER_TD = 4;
  // word slots inside one descriptor
  localparam int W_SRC  = 0;
  localparam int W_DST  = 1;
  localparam int W_CNT  = 2;
  localparam int W_CTRL = 3;
  // control word bit positions
  localparam int C_EOC  = 0;
  localparam int C_SINC = 1;
  localparam int C_DINC = 2;
  localparam int C_NEXT = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_MOVE} eng_state_t;
endpackage

// File: rtl/cdma_desc_ram.sv
module cdma_desc_ram #(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cdma_mover.sv
module cdma_mover #(
  parameter int          DATA_W    = 16,
  parameter int          DT_AW     = 5,
  parameter logic [15:0] DESC_BASE = 16'hF000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] go_src,
  input  logic [DATA_W-1:0] go_dst,
  input  logic [DATA_W-1:0] go_cnt,
  input  logic              go_sinc,
  input  logic              go_dinc,
  output logic              rd_en,
  output logic [DATA_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dt_we,
  output logic [DT_AW-1:0]  dt_addr,
  output logic              seg_fin
);
  localparam logic [DATA_W-1:0] BASE = DATA_W'(DESC_BASE);
  localparam int HI_W = DATA_W - DT_AW;

  logic              active_q, pend_q, sinc_q, dinc_q;
  logic [DATA_W-1:0] src_q, dst_q, rd_left_q, wr_left_q;
  logic              wr_en_q, dt_we_q, fin_q;
  logic [DATA_W-1:0] wr_addr_q, wr_data_q;
  logic              dst_hit;

  assign dst_hit = (dst_q[DATA_W-1:DT_AW] == BASE[DATA_W-1:DT_AW]);
  assign rd_en   = active_q && (rd_left_q != '0);
  assign rd_addr = src_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign dt_we   = dt_we_q;
  assign dt_addr = wr_addr_q[DT_AW-1:0];
  assign seg_fin = fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      pend_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      dt_we_q   <= 1'b0;
      fin_q     <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
      rd_left_q <= '0;
      wr_left_q <= '0;
      sinc_q    <= 1'b0;
      dinc_q    <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      pend_q  <= rd_en;
      wr_en_q <= 1'b0;
      dt_we_q <= 1'b0;
      fin_q   <= 1'b0;
      if (go) begin
        src_q     <= go_src;
        dst_q     <= go_dst;
        rd_left_q <= go_cnt;
        wr_left_q <= go_cnt;
        sinc_q    <= go_sinc;
        dinc_q    <= go_dinc;
        active_q  <= 1'b1;
      end else if (active_q) begin
        if (rd_en) begin
          src_q     <= src_q + DATA_W'(sinc_q);
          rd_left_q <= rd_left_q - DATA_W'(1);
        end
        if (pend_q) begin
          wr_addr_q <= dst_q;
          wr_data_q <= rd_data;
          if (dst_hit) dt_we_q <= 1'b1;
          else         wr_en_q <= 1'b1;
          dst_q     <= dst_q + DATA_W'(dinc_q);
          wr_left_q <= wr_left_q - DATA_W'(1);
          if (wr_left_q == DATA_W'(1)) begin
            active_q <= 1'b0;
            fin_q    <= 1'b1;
          end
        end
      end
    end
  end

  // R7: external writes never target the descriptor window
  a_r7_no_ext_in_window: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr[DATA_W-1:DT_AW] != BASE[DATA_W-1:DT_AW]));

  // R12: every write, to memory or table, trails its read by two cycles
  a_r12_write_after_read: assert property (@(posedge clk) disable iff (rst)
    (wr_en || dt_we) |-> $past(rd_en, 2));

  // R7: one write goes to exactly one destination
  a_r7_single_target: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && dt_we));

  localparam int UNUSED_HI = HI_W;
endmodule

// File: rtl/cdma_chain_engine.sv
module cdma_chain_engine #(
  parameter int          DATA_W    = 16,
  parameter int          NUM_TD    = 8,
  parameter logic [15:0] DESC_BASE = 16'hF000,
  localparam int         IDX_W     = $clog2(NUM_TD),
  localparam int         DT_AW     = IDX_W + $clog2(cdma_pkg::WORDS_PER_TD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DT_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  output logic              mem_rd_en,
  output logic [DATA_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              busy,
  output logic              done
);
  import cdma_pkg::*;

  localparam int SLOT_W = $clog2(WORDS_PER_TD);

  eng_state_t        state_q;
  logic [IDX_W-1:0]  idx_q, next_q;
  logic [2:0]        ld_q;
  logic [DATA_W-1:0] src_q, dst_q, cnt_q;
  logic              eoc_q, done_q;

  logic [DATA_W-1:0] dt_rdata, dt_wdata;
  logic [DT_AW-1:0]  dt_raddr, dt_waddr, mv_dt_addr;
  logic              dt_we, mv_dt_we, seg_fin, go;
  logic              ld_last, fin_now, fin_eoc;
  logic [IDX_W-1:0]  fin_next;
  logic [DATA_W-1:0] mv_wr_data;

  assign ld_last  = (state_q == ST_LOAD) && (ld_q == 3'(W_CTRL + 1));
  assign go       = ld_last && (cnt_q != '0);
  assign fin_now  = (ld_last && (cnt_q == '0)) || ((state_q == ST_MOVE) && seg_fin);
  assign fin_eoc  = ld_last ? dt_rdata[C_EOC] : eoc_q;
  assign fin_next = ld_last ? dt_rdata[C_NEXT +: IDX_W] : next_q;
  assign dt_raddr = {idx_q, ld_q[SLOT_W-1:0]};

  // engine writes only happen while busy, software writes only while idle
  assign dt_we    = mv_dt_we || (cfg_we && (state_q == ST_IDLE));
  assign dt_waddr = mv_dt_we ? mv_dt_addr : cfg_addr;
  assign dt_wdata = mv_dt_we ? mv_wr_data : cfg_wdata;

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign mem_wr_data = mv_wr_data;

  cdma_desc_ram #(.W(DATA_W), .AW(DT_AW)) u_table (
    .clk   (clk),
    .we    (dt_we),
    .waddr (dt_waddr),
    .wdata (dt_wdata),
    .raddr (dt_raddr),
    .rdata (dt_rdata)
  );

  cdma_mover #(.DATA_W(DATA_W), .DT_AW(DT_AW), .DESC_BASE(DESC_BASE)) u_mover (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .go_src  (src_q),
    .go_dst  (dst_q),
    .go_cnt  (cnt_q),
    .go_sinc (dt_rdata[C_SINC]),
    .go_dinc (dt_rdata[C_DINC]),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_rd_addr),
    .rd_data (mem_rd_data),
    .wr_en   (mem_wr_en),
    .wr_addr (mem_wr_addr),
    .wr_data (mv_wr_data),
    .dt_we   (mv_dt_we),
    .dt_addr (mv_dt_addr),
    .seg_fin (seg_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      next_q  <= '0;
      ld_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      eoc_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            idx_q   <= start_idx;
            ld_q    <= '0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          ld_q <= ld_q + 3'd1;
          // table read issued in slot k returns during slot k+1
          if (ld_q == 3'(W_SRC + 1)) src_q <= dt_rdata;
          if (ld_q == 3'(W_DST + 1)) dst_q <= dt_rdata;
          if (ld_q == 3'(W_CNT + 1)) cnt_q <= dt_rdata;
          if (ld_last) begin
            eoc_q  <= dt_rdata[C_EOC];
            next_q <= dt_rdata[C_NEXT +: IDX_W];
            if (cnt_q != '0) state_q <= ST_MOVE;
          end
        end
        ST_MOVE: ;
        default: state_q <= ST_IDLE;
      endcase
      if (fin_now) begin
        if (fin_eoc) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          idx_q   <= fin_next;
          ld_q    <= '0;
          state_q <= ST_LOAD;
        end
      end
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: completion is flagged only once the engine is idle
  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd_en && !mem_wr_en));

  // R10: a zero-count descriptor never starts a read
  a_r10_zero_no_read: assert property (@(posedge clk) disable iff (rst)
    (ld_last && (cnt_q == '0)) |=> !mem_rd_en);
endmodule

// File: tb/cdma_chain_engine_tb.sv
module cdma_chain_engine_tb;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 3;
  localparam int DT_AW  = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we;
  logic [DT_AW-1:0]  cfg_addr;
  logic [DATA_W-1:0] cfg_wdata;
  logic              start;
  logic [IDX_W-1:0]  start_idx;
  logic              mem_rd_en, mem_wr_en, busy, done;
  logic [DATA_W-1:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;

  logic [DATA_W-1:0] ext [1024];
  int total = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, cur_run = 0, max_run = 0;

  always #2.5 clk = ~clk;

  cdma_chain_engine #(.DATA_W(DATA_W), .NUM_TD(8), .DESC_BASE(16'hF000)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .start_idx(start_idx),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= ext[mem_rd_addr[9:0]];
    if (mem_wr_en) ext[mem_wr_addr[9:0]] <= mem_wr_data;
    if (mem_rd_en) begin rd_cnt++; cur_run++; if (cur_run > max_run) max_run = cur_run; end
    else cur_run = 0;
    if (mem_wr_en) wr_cnt++;
    if (done) done_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input int nxt, input bit eoc, input bit si, input bit di);
    return 16'((nxt << 3) | (int'(di) << 2) | (int'(si) << 1) | int'(eoc));
  endfunction

  task automatic cfg_word(input int a, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = DT_AW'(a); cfg_wdata = DATA_W'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_td(input int idx, input int s, input int d, input int n, input logic [15:0] c);
    cfg_word(idx*4 + 0, s);
    cfg_word(idx*4 + 1, d);
    cfg_word(idx*4 + 2, n);
    cfg_word(idx*4 + 3, int'(c));
  endtask

  task automatic run_chain(input int idx, input string req);
    bit got = 1'b0;
    @(negedge clk);
    start = 1'b1; start_idx = IDX_W'(idx);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (done) got = 1'b1; else @(negedge clk);
    end
    chk({req, " chain completes"}, int'(got), 1);
    if (got) begin
      chk("R9 busy low with done", int'(busy), 0);
      @(negedge clk);
      chk("R9 done lasts one cycle", int'(done), 0);
    end
  endtask

  task automatic test_reset;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 no read after reset", int'(mem_rd_en), 0);
    chk("R1 no write after reset", int'(mem_wr_en), 0);
  endtask

  task automatic test_single;
    int r0;
    for (int i = 0; i < 4; i++) ext[100+i] = 16'hA000 + 16'(i);
    set_td(0, 100, 200, 4, ctl(0, 1, 1, 1));
    r0 = rd_cnt; max_run = 0;
    run_chain(0, "R3");
    for (int i = 0; i < 4; i++) chk("R3 single copy", int'(ext[200+i]), 'hA000 + i);
    chk("R2 table layout drives one run", rd_cnt - r0, 4);
    chk("R12 back-to-back reads", max_run, 4);
  endtask

  task automatic test_gather;
    ext[300] = 16'h1111; ext[301] = 16'h1112;
    for (int i = 0; i < 4; i++) ext[320+i] = 16'h2220 + 16'(i);
    ext[350] = 16'h3333;
    set_td(1, 300, 400, 2, ctl(4, 0, 1, 1));
    set_td(4, 320, 402, 4, ctl(2, 0, 1, 1));
    set_td(2, 350, 406, 1, ctl(0, 1, 1, 1));
    run_chain(1, "R4");
    chk("R4 header", int'(ext[401]), 'h1112);
    chk("R4 payload", int'(ext[405]), 'h2223);
    chk("R4 trailer", int'(ext[406]), 'h3333);
  endtask

  task automatic test_scatter;
    for (int i = 0; i < 6; i++) ext[500+i] = 16'h5000 + 16'(i);
    set_td(5, 500, 600, 2, ctl(6, 0, 1, 1));
    set_td(6, 502, 650, 3, ctl(7, 0, 1, 1));
    set_td(7, 505, 700, 1, ctl(0, 1, 1, 1));
    run_chain(5, "R5");
    chk("R5 region a", int'(ext[601]), 'h5001);
    chk("R5 region b", int'(ext[652]), 'h5004);
    chk("R5 region c", int'(ext[700]), 'h5005);
  endtask

  task automatic test_fixed;
    ext[110] = 16'h7777; ext[111] = 16'h0001;
    set_td(0, 110, 210, 3, ctl(0, 1, 0, 1));
    run_chain(0, "R6");
    chk("R6 fixed source word0", int'(ext[210]), 'h7777);
    chk("R6 fixed source word2", int'(ext[212]), 'h7777);
    for (int i = 0; i < 3; i++) ext[120+i] = 16'h8880 + 16'(i);
    ext[221] = 16'hBEEF;
    set_td(0, 120, 220, 3, ctl(0, 1, 1, 0));
    run_chain(0, "R6");
    chk("R6 fixed dest keeps last", int'(ext[220]), 'h8882);
    chk("R6 fixed dest no spill", int'(ext[221]), 'hBEEF);
  endtask

  task automatic test_zero;
    int r0, w0;
    ext[130] = 16'h4242;
    set_td(1, 0, 0, 0, ctl(2, 0, 1, 1));
    set_td(2, 130, 230, 1, ctl(0, 1, 1, 1));
    r0 = rd_cnt;
    run_chain(1, "R10");
    chk("R10 zero count then link", int'(ext[230]), 'h4242);
    chk("R10 zero count no extra read", rd_cnt - r0, 1);
    set_td(3, 130, 231, 0, ctl(0, 1, 1, 1));
    r0 = rd_cnt; w0 = wr_cnt;
    run_chain(3, "R10");
    chk("R10 zero-only chain no read", rd_cnt - r0, 0);
    chk("R10 zero-only chain no write", wr_cnt - w0, 0);
  endtask

  task automatic test_window;
    int w0;
    for (int i = 8; i < 13; i++) ext[i] = 16'hCAFE;
    ext[140] = 16'h6001; ext[141] = 16'h6002;
    ext[150] = 16'd140; ext[151] = 16'd240; ext[152] = 16'd2; ext[153] = ctl(0, 1, 1, 1);
    set_td(0, 150, 16'hF008, 4, ctl(2, 0, 1, 1));
    set_td(2, 0, 0, 0, ctl(0, 1, 1, 1));
    w0 = wr_cnt;
    run_chain(0, "R7");
    chk("R7 rewritten descriptor runs", int'(ext[241]), 'h6002);
    chk("R7 only data writes external", wr_cnt - w0, 2);
    chk("R7 aliased memory untouched", int'(ext[8]), 'hCAFE);
  endtask

  task automatic test_nested;
    int r0;
    ext[160] = 16'h9001; ext[161] = 16'h9002;
    ext[170] = 16'h9101; ext[171] = 16'h9102; ext[172] = 16'h9103;
    ext[250] = 16'h0; ext[252] = 16'h0;
    ext[180] = 16'd160; ext[181] = 16'd250; ext[182] = 16'd2;
    ext[183] = ctl(3, 0, 1, 1); ext[184] = 16'd185;
    ext[185] = 16'd170; ext[186] = 16'd260; ext[187] = 16'd3;
    ext[188] = ctl(0, 1, 1, 1); ext[189] = 16'd0;
    set_td(3, 180, 16'hF008, 5, ctl(2, 0, 1, 1));
    set_td(2, 0, 0, 0, ctl(0, 1, 1, 1));
    r0 = rd_cnt; done_cnt = 0;
    run_chain(3, "R8");
    chk("R8 first pass data", int'(ext[251]), 'h9002);
    chk("R8 second pass data", int'(ext[262]), 'h9103);
    chk("R8 reads across loop", rd_cnt - r0, 15);
    chk("R8 single completion", done_cnt, 1);
  endtask

  task automatic test_busy;
    for (int i = 0; i < 8; i++) ext[190+i] = 16'hD000 + 16'(i);
    ext[270] = 16'h0; ext[280] = 16'hFACE;
    set_td(0, 190, 290, 8, ctl(1, 0, 1, 1));
    set_td(1, 190, 270, 2, ctl(0, 1, 1, 1));
    done_cnt = 0;
    @(negedge clk);
    start = 1'b1; start_idx = 3'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'd5; cfg_wdata = 16'd280;
    start = 1'b1; start_idx = 3'd3;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    repeat (60) @(negedge clk);
    chk("R11 table write ignored while busy", int'(ext[271]), 'hD001);
    chk("R11 stray target untouched", int'(ext[280]), 'hFACE);
    chk("R11 start ignored while busy", done_cnt, 1);
    chk("R11 idle afterwards", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) ext[i] = 16'h0;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; start = 1'b0; start_idx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_single();
    test_gather();
    test_scatter();
    test_fixed();
    test_zero();
    test_window();
    test_nested();
    test_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule